// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block brings a DDR2 or mobile DDR SDRAM from power-up to a usable idle state. It drives the SDRAM command pins itself. It holds clock-enable low for a programmable settling time, closes all banks, and loads the mode and extended mode registers. It then issues the refresh commands the device needs and finishes with every bank closed. Four enable bits select which of the two memory flavours the sequence targets. The gaps between commands are set by parameters, counted in clock cycles.

There are two ways to start the sequence. Releasing either of two active-low reset inputs starts it at once, and anything waiting in the controller's command queue is thrown away. A write to one of four configuration fields also starts it: drive strength, CAS latency, bank count or page size. In that case the block first asks the command queue to drain, and it waits until the queue reports that all outstanding reads and writes are finished. It raises busy for the whole run and a one-cycle done pulse at the end. While busy is high, requests for new traffic are not granted.

Top module: `sdram_boot_seq`

## Requirements
- R1: The sequence runs only when `mode_en_i` is 4'b1011 (SDRAM, not mobile, DDR, DDR2: the DDR2 flavour) or 4'b1110 (SDRAM, mobile, DDR, not DDR2: the mobile flavour). With any other value a trigger issues no command and no done pulse, and busy falls back low after the trigger.
- R2: While either `chip_rst_n` or `mod_rst_n` is low, `flush_o` and `busy_o` are high, CKE is low, `sd_cs_n_o` is high and `drain_req_o` is low. On the first clock edge with both resets high the sequence starts, with no drain phase.
- R3: A cycle with `cfg_we_i` high and a nonzero `cfg_field_i` starts a restart: bit0 = drive strength, bit1 = CAS latency, bit2 = bank count, bit3 = page size. From the next cycle `drain_req_o` and `busy_o` are high and no command is issued until `pend_done_i` is sampled high. The cycle after that sample is the first cycle of the sequence. A write with `cfg_field_i` = 0 has no effect.
- R4: The sequence opens with T_PWRUP+1 cycles with CKE low and no command. In the next cycle CKE goes high and a precharge-all is issued: command code 0010 on {cs_n,ras_n,cas_n,we_n}, address bit 10 set, BA = 0. Every precharge in the sequence has address bit 10 set.
- R5: DDR2 order: precharge-all, mode set with BA=2 and address 0, mode set with BA=3 and address 0, mode set with BA=1, main mode set with DLL reset, precharge-all, refresh, refresh, main mode set without DLL reset, refresh. Each command is followed by T_RP (precharge), T_MRD (mode set) or T_RFC (refresh) idle cycles.
- R6: The mobile flavour uses the same order without the BA=2 and BA=3 writes. Its extended register is written with BA=2, and it never writes BA=3.
- R7: The main mode word (BA=0, code 0000) carries the burst-length code BL_CODE in address [2:0], a 0 in bit 3 (sequential burst) and the CAS latency in [6:4]. Bit 8 (DLL reset) is 1 only in the first DDR2 main write. All other bits are 0.
- R8: The DDR2 extended word (BA=1) has bit 1 = `drv_reduced_i` and bit 0 = 0 (DLL on). The mobile extended word (BA=2) has bit 5 = `drv_reduced_i`. All other bits of these words are 0, and in DDR2 the words written to BA=2 and BA=3 are entirely 0.
- R9: `busy_o` stays high from the trigger until the final refresh wait ends. In the cycle after that, `busy_o` is low and `done_o` is high for exactly one cycle.
- R10: `traffic_gnt_o` is high only while `busy_o` is low and `traffic_req_i` is high.
- R11: Each command lasts one cycle. In every cycle without a command, cs_n, ras_n, cas_n and we_n are all high and BA and the address are 0. Refresh uses code 0001.
- R12: A qualifying configuration write during a run abandons that run and enters the drain phase. The new sequence starts again from the power-up wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| chip_rst_n | input | 1 | Chip-level reset, active low |
| mod_rst_n | input | 1 | Module-level reset, active low |
| mode_en_i | input | 4 | {sdram, mobile, ddr, ddr2} enable bits |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_field_i | input | 4 | Fields touched by the write |
| cas_lat_i | input | 3 | CAS latency code for the main mode word |
| drv_reduced_i | input | 1 | Reduced output drive request |
| pend_done_i | input | 1 | Command queue has no outstanding reads or writes |
| traffic_req_i | input | 1 | Normal traffic wants the pins |
| drain_req_o | output | 1 | Ask the queue to finish outstanding work |
| flush_o | output | 1 | Queued work is being discarded (reset start) |
| busy_o | output | 1 | Initialization in progress |
| done_o | output | 1 | One-cycle completion pulse |
| traffic_gnt_o | output | 1 | Normal traffic may proceed |
| sd_cke_o | output | 1 | SDRAM clock enable |
| sd_cs_n_o | output | 1 | Chip select, active low |
| sd_ras_n_o | output | 1 | Row strobe, active low |
| sd_cas_n_o | output | 1 | Column strobe, active low |
| sd_we_n_o | output | 1 | Write enable, active low |
| sd_ba_o | output | 2 | Bank address |
| sd_addr_o | output | ADDR_W | Address bus |

## Verification
The pins are compared cycle by cycle over a full run for both flavours, every CAS latency code and both drive settings. This separates a wrong step order, wrong spacing or wrong mode-word bits from a correct run. Restarts come from each of the four field bits with drain waits of different lengths, so a sequence that starts too early, before the queue reports done, is caught. All fourteen unsupported enable codes are applied, which shows that decoding is exact and not based on some of the bits. Releasing each reset in the middle of a run, and writing the configuration in the middle of a run, checks that both restart paths abandon the old sequence and begin again from the power-up wait.

// File: rtl/sdram_boot_pkg.sv
package sdram_boot_pkg;

  typedef enum logic [1:0] {ST_ARM, ST_IDLE, ST_DRAIN, ST_RUN} boot_state_t;

  typedef enum logic [3:0] {
    SP_PWR, SP_PREA1, SP_EMR2, SP_EMR3, SP_EMR1, SP_MR_DLL,
    SP_PREA2, SP_REF1, SP_REF2, SP_MR, SP_REF_LAST
  } boot_step_t;

  // {cs_n, ras_n, cas_n, we_n}
  localparam logic [3:0] CMD_DESEL = 4'b1111;
  localparam logic [3:0] CMD_PRE   = 4'b0010;
  localparam logic [3:0] CMD_REF   = 4'b0001;
  localparam logic [3:0] CMD_MRS   = 4'b0000;

  localparam logic [3:0] MODE_DDR2 = 4'b1011;
  localparam logic [3:0] MODE_MDDR = 4'b1110;

  localparam int PALL_BIT = 10;

  function automatic logic mode_ok(logic [3:0] m);
    return (m == MODE_DDR2) || (m == MODE_MDDR);
  endfunction

  function automatic boot_step_t next_step(boot_step_t s, logic mddr);
    if (mddr && s == SP_PREA1) return SP_EMR1;
    return boot_step_t'(s + 4'd1);
  endfunction

  function automatic logic [15:0] mr_bits(logic [2:0] bl, logic [2:0] cl, logic dll_rst);
    logic [15:0] w;
    w      = '0;
    w[2:0] = bl;
    w[3]   = 1'b0;
    w[6:4] = cl;
    w[8]   = dll_rst;
    return w;
  endfunction

  function automatic logic [15:0] emr_bits(logic mddr, logic drv);
    logic [15:0] w;
    w = '0;
    if (mddr) w[5] = drv;
    else      w[1] = drv;
    return w;
  endfunction

endpackage

// File: rtl/boot_timer.sv
module boot_timer #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] cnt,
  output logic             expired
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (clear) cnt <= '0;
    else            cnt <= cnt + 1'b1;
  end

  assign expired = (cnt == limit);

endmodule

// File: rtl/boot_ctrl.sv
module boot_ctrl
  import sdram_boot_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  mode_en,
  input  logic        cfg_we,
  input  logic [3:0]  cfg_field,
  input  logic [2:0]  cas_lat,
  input  logic        drv_reduced,
  input  logic        pend_done,
  input  logic        expired,
  output boot_state_t st,
  output boot_step_t  step,
  output logic        mddr_q,
  output logic [2:0]  cl_q,
  output logic        drv_q,
  output logic        run_start,
  output logic        step_adv,
  output logic        done_q
);

  boot_state_t st_nxt;
  logic cfg_hit, ok, last, finish;

  assign cfg_hit = cfg_we & (|cfg_field) & (st != ST_ARM);
  assign ok      = mode_ok(mode_en);
  assign last    = (step == SP_REF_LAST);

  always_comb begin
    st_nxt = st;
    unique case (st)
      ST_ARM:   st_nxt = ok ? ST_RUN : ST_IDLE;
      ST_IDLE:  if (cfg_hit) st_nxt = ST_DRAIN;
      ST_DRAIN: if (!cfg_hit && pend_done) st_nxt = ok ? ST_RUN : ST_IDLE;
      ST_RUN: begin
        if (cfg_hit)              st_nxt = ST_DRAIN;
        else if (expired && last) st_nxt = ST_IDLE;
      end
      default:  st_nxt = ST_IDLE;
    endcase
  end

  assign run_start = (st != ST_RUN) && (st_nxt == ST_RUN);
  assign step_adv  = (st == ST_RUN) && !cfg_hit && expired && !last;
  assign finish    = (st == ST_RUN) && !cfg_hit && expired && last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_ARM;
      step   <= SP_PWR;
      mddr_q <= 1'b0;
      cl_q   <= '0;
      drv_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st     <= st_nxt;
      done_q <= finish;
      if (run_start) begin
        step   <= SP_PWR;
        mddr_q <= (mode_en == MODE_MDDR);
        cl_q   <= cas_lat;
        drv_q  <= drv_reduced;
      end else if (step_adv) begin
        step <= next_step(step, mddr_q);
      end
    end
  end

endmodule

// File: rtl/boot_cmd_gen.sv
module boot_cmd_gen
  import sdram_boot_pkg::*;
#(
  parameter int         ADDR_W  = 13,
  parameter logic [2:0] BL_CODE = 3'b010,
  parameter int         T_PWRUP = 20,
  parameter int         T_RP    = 3,
  parameter int         T_MRD   = 2,
  parameter int         T_RFC   = 8,
  parameter int         CNT_W   = 5
) (
  input  logic              running,
  input  boot_step_t        step,
  input  logic              first,
  input  logic              mddr,
  input  logic [2:0]        cl,
  input  logic              drv,
  input  logic              cke_hold,
  output logic              cke,
  output logic [3:0]        cmd,
  output logic [1:0]        ba,
  output logic [ADDR_W-1:0] addr,
  output logic [CNT_W-1:0]  limit
);

  logic [15:0] word;

  always_comb begin
    cmd  = CMD_DESEL;
    ba   = 2'b00;
    word = '0;
    if (running && first) begin
      case (step)
        SP_PREA1, SP_PREA2: begin
          cmd            = CMD_PRE;
          word[PALL_BIT] = 1'b1;
        end
        SP_EMR2: begin
          cmd = CMD_MRS;
          ba  = 2'b10;
        end
        SP_EMR3: begin
          cmd = CMD_MRS;
          ba  = 2'b11;
        end
        SP_EMR1: begin
          cmd  = CMD_MRS;
          ba   = mddr ? 2'b10 : 2'b01;
          word = emr_bits(mddr, drv);
        end
        SP_MR_DLL: begin
          cmd  = CMD_MRS;
          word = mr_bits(BL_CODE, cl, !mddr);
        end
        SP_MR: begin
          cmd  = CMD_MRS;
          word = mr_bits(BL_CODE, cl, 1'b0);
        end
        SP_REF1, SP_REF2, SP_REF_LAST: cmd = CMD_REF;
        default: cmd = CMD_DESEL;
      endcase
    end
  end

  assign addr = word[ADDR_W-1:0];
  assign cke  = running ? (step != SP_PWR) : cke_hold;

  always_comb begin
    case (step)
      SP_PWR:                           limit = CNT_W'(T_PWRUP);
      SP_PREA1, SP_PREA2:               limit = CNT_W'(T_RP);
      SP_REF1, SP_REF2, SP_REF_LAST:    limit = CNT_W'(T_RFC);
      default:                          limit = CNT_W'(T_MRD);
    endcase
  end

endmodule

// File: rtl/sdram_boot_seq.sv
module sdram_boot_seq
  import sdram_boot_pkg::*;
#(
  parameter int         ADDR_W  = 13,
  parameter logic [2:0] BL_CODE = 3'b010,
  parameter int         T_PWRUP = 20,
  parameter int         T_RP    = 3,
  parameter int         T_MRD   = 2,
  parameter int         T_RFC   = 8
) (
  input  logic              clk,
  input  logic              chip_rst_n,
  input  logic              mod_rst_n,
  input  logic [3:0]        mode_en_i,
  input  logic              cfg_we_i,
  input  logic [3:0]        cfg_field_i,
  input  logic [2:0]        cas_lat_i,
  input  logic              drv_reduced_i,
  input  logic              pend_done_i,
  input  logic              traffic_req_i,
  output logic              drain_req_o,
  output logic              flush_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              traffic_gnt_o,
  output logic              sd_cke_o,
  output logic              sd_cs_n_o,
  output logic              sd_ras_n_o,
  output logic              sd_cas_n_o,
  output logic              sd_we_n_o,
  output logic [1:0]        sd_ba_o,
  output logic [ADDR_W-1:0] sd_addr_o
);

  localparam int MAX_A    = (T_PWRUP > T_RFC) ? T_PWRUP : T_RFC;
  localparam int MAX_B    = (T_RP > T_MRD) ? T_RP : T_MRD;
  localparam int MAX_WAIT = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W    = $clog2(MAX_WAIT + 1);

  logic             any_rst_n;
  boot_state_t      st;
  boot_step_t       step;
  logic             mddr_q, drv_q, run_start, step_adv, done_q;
  logic [2:0]       cl_q;
  logic [CNT_W-1:0] cnt, limit;
  logic             expired, cke_w, cke_hold_q;
  logic [3:0]       cmd;
  logic             run_mddr;

  assign any_rst_n = chip_rst_n & mod_rst_n;

  boot_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (any_rst_n),
    .mode_en     (mode_en_i),
    .cfg_we      (cfg_we_i),
    .cfg_field   (cfg_field_i),
    .cas_lat     (cas_lat_i),
    .drv_reduced (drv_reduced_i),
    .pend_done   (pend_done_i),
    .expired     (expired),
    .st          (st),
    .step        (step),
    .mddr_q      (mddr_q),
    .cl_q        (cl_q),
    .drv_q       (drv_q),
    .run_start   (run_start),
    .step_adv    (step_adv),
    .done_q      (done_q)
  );

  boot_timer #(.CNT_W(CNT_W)) u_timer (
    .clk     (clk),
    .rst_n   (any_rst_n),
    .clear   (run_start | step_adv),
    .limit   (limit),
    .cnt     (cnt),
    .expired (expired)
  );

  boot_cmd_gen #(
    .ADDR_W  (ADDR_W),
    .BL_CODE (BL_CODE),
    .T_PWRUP (T_PWRUP),
    .T_RP    (T_RP),
    .T_MRD   (T_MRD),
    .T_RFC   (T_RFC),
    .CNT_W   (CNT_W)
  ) u_cmd (
    .running  (st == ST_RUN),
    .step     (step),
    .first    (cnt == '0),
    .mddr     (mddr_q),
    .cl       (cl_q),
    .drv      (drv_q),
    .cke_hold (cke_hold_q),
    .cke      (cke_w),
    .cmd      (cmd),
    .ba       (sd_ba_o),
    .addr     (sd_addr_o),
    .limit    (limit)
  );

  always_ff @(posedge clk or negedge any_rst_n) begin
    if (!any_rst_n) cke_hold_q <= 1'b0;
    else            cke_hold_q <= cke_w;
  end

  assign run_mddr      = mddr_q & (st == ST_RUN);
  assign sd_cke_o      = cke_w;
  assign {sd_cs_n_o, sd_ras_n_o, sd_cas_n_o, sd_we_n_o} = cmd;
  assign busy_o        = (st != ST_IDLE);
  assign drain_req_o   = (st == ST_DRAIN);
  assign flush_o       = (st == ST_ARM);
  assign done_o        = done_q;
  assign traffic_gnt_o = traffic_req_i & ~busy_o;

endmodule

// File: rtl/sdram_boot_chk.sv
module sdram_boot_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       done,
  input logic       drain,
  input logic       flush,
  input logic       cke,
  input logic       cs_n,
  input logic       ras_n,
  input logic       cas_n,
  input logic       we_n,
  input logic [1:0] ba,
  input logic       addr10,
  input logic       run_mddr
);

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_after_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(busy) && !busy));

  assert_no_cmd_cke_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |-> cs_n);

  assert_pre_all_banks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !ras_n && cas_n && !we_n) |-> addr10);

  assert_cmd_only_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> busy);

  assert_cmd_one_cycle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |=> cs_n);

  assert_drain_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    drain |-> (cs_n && busy));

  assert_mobile_no_emr3_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !ras_n && !cas_n && !we_n && ba == 2'b11) |-> !run_mddr);

  assert_flush_state_R2: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (busy && !cke && !drain));

endmodule

bind sdram_boot_seq sdram_boot_chk u_chk (
  .clk      (clk),
  .rst_n    (any_rst_n),
  .busy     (busy_o),
  .done     (done_o),
  .drain    (drain_req_o),
  .flush    (flush_o),
  .cke      (sd_cke_o),
  .cs_n     (sd_cs_n_o),
  .ras_n    (sd_ras_n_o),
  .cas_n    (sd_cas_n_o),
  .we_n     (sd_we_n_o),
  .ba       (sd_ba_o),
  .addr10   (sd_addr_o[10]),
  .run_mddr (run_mddr)
);

// File: tb/sdram_boot_seq_tb.sv
`timescale 1ns/1ps
module sdram_boot_seq_tb;

  localparam int TPW = 20, TRP = 3, TMRD = 2, TRFC = 8;
  localparam logic [2:0] BL = 3'b010;

  logic clk = 1'b0;
  logic chip_rst_n = 1'b0, mod_rst_n = 1'b1;
  logic [3:0] mode_en_i = 4'b1011;
  logic cfg_we_i = 1'b0;
  logic [3:0] cfg_field_i = 4'b0;
  logic [2:0] cas_lat_i = 3'd3;
  logic drv_reduced_i = 1'b0, pend_done_i = 1'b0, traffic_req_i = 1'b1;
  logic drain_req_o, flush_o, busy_o, done_o, traffic_gnt_o;
  logic sd_cke_o, sd_cs_n_o, sd_ras_n_o, sd_cas_n_o, sd_we_n_o;
  logic [1:0] sd_ba_o;
  logic [12:0] sd_addr_o;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  sdram_boot_seq #(.ADDR_W(13), .BL_CODE(BL), .T_PWRUP(TPW), .T_RP(TRP),
                   .T_MRD(TMRD), .T_RFC(TRFC)) u_dut (
    .clk(clk), .chip_rst_n(chip_rst_n), .mod_rst_n(mod_rst_n),
    .mode_en_i(mode_en_i), .cfg_we_i(cfg_we_i), .cfg_field_i(cfg_field_i),
    .cas_lat_i(cas_lat_i), .drv_reduced_i(drv_reduced_i),
    .pend_done_i(pend_done_i), .traffic_req_i(traffic_req_i),
    .drain_req_o(drain_req_o), .flush_o(flush_o), .busy_o(busy_o),
    .done_o(done_o), .traffic_gnt_o(traffic_gnt_o), .sd_cke_o(sd_cke_o),
    .sd_cs_n_o(sd_cs_n_o), .sd_ras_n_o(sd_ras_n_o), .sd_cas_n_o(sd_cas_n_o),
    .sd_we_n_o(sd_we_n_o), .sd_ba_o(sd_ba_o), .sd_addr_o(sd_addr_o));

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int run_len(bit mddr);
    return (TPW + 1) + 2 * (TRP + 1) + (mddr ? 3 : 5) * (TMRD + 1) + 3 * (TRFC + 1);
  endfunction

  // expected {cke, cs_n, ras_n, cas_n, we_n, ba, addr} in cycle k of a run
  function automatic logic [19:0] exp_pins(int k, bit mddr, int cl, bit drv,
                                           output string tag);
    int t = 0;
    int len;
    logic [12:0] ad;
    tag = "R11";
    for (int i = 0; i < 11; i++) begin
      if (mddr && (i == 2 || i == 3)) continue;
      case (i)
        0:        len = TPW + 1;
        1, 6:     len = TRP + 1;
        7, 8, 10: len = TRFC + 1;
        default:  len = TMRD + 1;
      endcase
      if (k >= t && k < t + len) begin
        if (i == 0) begin tag = "R4"; return {1'b0, 4'b1111, 15'd0}; end
        if (k != t) return {1'b1, 4'b1111, 15'd0};
        case (i)
          1, 6: begin tag = "R4"; return {1'b1, 4'b0010, 2'd0, 13'h400}; end
          2: begin tag = "R8"; return {1'b1, 4'b0000, 2'd2, 13'd0}; end
          3: begin tag = "R8"; return {1'b1, 4'b0000, 2'd3, 13'd0}; end
          4: begin
            tag = mddr ? "R6" : "R8";
            ad = mddr ? (13'(drv) << 5) : (13'(drv) << 1);
            return {1'b1, 4'b0000, (mddr ? 2'd2 : 2'd1), ad};
          end
          5, 9: begin
            tag = "R7";
            ad = 13'(BL) | (13'(cl) << 4);
            if (i == 5 && !mddr) ad = ad | 13'h100;
            return {1'b1, 4'b0000, 2'd0, ad};
          end
          default: begin tag = mddr ? "R6" : "R5"; return {1'b1, 4'b0001, 15'd0}; end
        endcase
      end
      t += len;
    end
    return {1'b1, 4'b1111, 15'd0};
  endfunction

  // first negedge sampled is cycle 0 of the run
  task automatic sample_run(input bit mddr, input int cl, input bit drv);
    int total = run_len(mddr);
    logic [19:0] got, exp;
    string tag;
    for (int k = 0; k <= total + 1; k++) begin
      @(negedge clk);
      got = {sd_cke_o, sd_cs_n_o, sd_ras_n_o, sd_cas_n_o, sd_we_n_o, sd_ba_o, sd_addr_o};
      exp = exp_pins(k, mddr, cl, drv, tag);
      check(got === exp, tag, 32'(got), 32'(exp));
      if (k < total) begin
        check(busy_o && !done_o, "R9", {busy_o, done_o}, 2'b10);
        check(!traffic_gnt_o, "R10", traffic_gnt_o, 0);
      end else if (k == total) begin
        check(!busy_o && done_o, "R9", {busy_o, done_o}, 2'b01);
        check(traffic_gnt_o, "R10", traffic_gnt_o, 1);
      end else begin
        check(!done_o, "R9", done_o, 0);
      end
    end
  endtask

  task automatic cfg_trigger(input logic [3:0] mask, input int w, input bit mddr,
                             input int cl, input bit drv);
    @(negedge clk);
    cfg_we_i = 1'b1; cfg_field_i = mask; pend_done_i = 1'b0;
    @(negedge clk);
    cfg_we_i = 1'b0; cfg_field_i = 4'b0;
    for (int i = 0; i <= w; i++) begin
      check(drain_req_o && busy_o && sd_cs_n_o, "R3",
            {drain_req_o, busy_o, sd_cs_n_o}, 3'b111);
      if (i < w) @(negedge clk);
    end
    pend_done_i = 1'b1;
    sample_run(mddr, cl, drv);
    pend_done_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // R2: reset state, then immediate start on release
    repeat (3) @(negedge clk);
    check(flush_o && busy_o && !sd_cke_o && sd_cs_n_o && !drain_req_o, "R2",
          {flush_o, busy_o, sd_cke_o, sd_cs_n_o, drain_req_o}, 5'b11010);
    chip_rst_n = 1'b1;
    sample_run(1'b0, 3, 1'b0);

    // R5 R6 R7 R8: sweep flavours, CAS latency, drive; R3 via each field bit
    for (int md = 0; md < 2; md++)
      for (int cl = 0; cl < 8; cl++)
        for (int dv = 0; dv < 2; dv++) begin
          mode_en_i = md ? 4'b1110 : 4'b1011;
          cas_lat_i = 3'(cl);
          drv_reduced_i = dv[0];
          cfg_trigger(4'(1 << (cl % 4)), cl % 3, md[0], cl, dv[0]);
        end

    // R3: write with no field bit has no effect
    @(negedge clk); cfg_we_i = 1'b1; cfg_field_i = 4'b0000;
    @(negedge clk); cfg_we_i = 1'b0;
    for (int i = 0; i < 4; i++) begin
      check(!busy_o && !drain_req_o && sd_cs_n_o, "R3",
            {busy_o, drain_req_o, sd_cs_n_o}, 3'b001);
      @(negedge clk);
    end

    // R1: every unsupported enable code
    for (int m = 0; m < 16; m++) begin
      if (m == 4'b1011 || m == 4'b1110) continue;
      mode_en_i = 4'(m);
      @(negedge clk); cfg_we_i = 1'b1; cfg_field_i = 4'b1000; pend_done_i = 1'b1;
      @(negedge clk); cfg_we_i = 1'b0; cfg_field_i = 4'b0;
      for (int i = 0; i < 6; i++) begin
        @(negedge clk);
        check(!busy_o && !done_o && sd_cs_n_o, "R1",
              {busy_o, done_o, sd_cs_n_o}, 3'b001);
      end
      pend_done_i = 1'b0;
    end

    // R12: configuration write in the middle of a run
    mode_en_i = 4'b1011; cas_lat_i = 3'd5; drv_reduced_i = 1'b1;
    @(negedge clk); cfg_we_i = 1'b1; cfg_field_i = 4'b0100; pend_done_i = 1'b1;
    @(negedge clk); cfg_we_i = 1'b0; cfg_field_i = 4'b0;
    repeat (40) @(negedge clk);
    check(busy_o, "R12", busy_o, 1);
    cfg_trigger(4'b0010, 3, 1'b0, 5, 1'b1);

    // R2: module reset in the middle of a mobile run
    mode_en_i = 4'b1110; cas_lat_i = 3'd2; drv_reduced_i = 1'b0;
    @(negedge clk); cfg_we_i = 1'b1; cfg_field_i = 4'b0001; pend_done_i = 1'b1;
    @(negedge clk); cfg_we_i = 1'b0; cfg_field_i = 4'b0;
    repeat (30) @(negedge clk);
    mod_rst_n = 1'b0;
    pend_done_i = 1'b0;
    @(negedge clk);
    check(flush_o && busy_o && !sd_cke_o && sd_cs_n_o && !drain_req_o, "R2",
          {flush_o, busy_o, sd_cke_o, sd_cs_n_o, drain_req_o}, 5'b11010);
    mod_rst_n = 1'b1;
    sample_run(1'b1, 2, 1'b0);

    // R2: chip reset in the middle of a DDR2 run
    mode_en_i = 4'b1011;
    @(negedge clk); cfg_we_i = 1'b1; cfg_field_i = 4'b1000; pend_done_i = 1'b1;
    @(negedge clk); cfg_we_i = 1'b0; cfg_field_i = 4'b0;
    repeat (50) @(negedge clk);
    chip_rst_n = 1'b0;
    @(negedge clk);
    check(flush_o && !sd_cke_o, "R2", {flush_o, sd_cke_o}, 2'b10);
    chip_rst_n = 1'b1;
    sample_run(1'b0, 2, 1'b0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule